// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This engine runs once after a NAND array is attached and builds a map of the blocks that left the factory marked unusable. It walks the blocks in ascending order starting from block 0. For each block it reads the first spare-area byte, which sits at column 2048, from page 0 and, if needed, from page 1. A block counts as bad when either byte is anything other than the erased value FFh. The result goes into a one-bit-per-block map. Software or a later translation layer reads that map through a combinational index port.

Reads go to a lower-level NAND port through a minimal request interface. The scanner presents a row and a column, pulses a start strobe, and waits for a done strobe that carries the byte. The port handles the command and address cycles. The only operation the scanner ever asks for is a read, because erasing or programming a block would destroy a marker that cannot be rebuilt.

When the walk ends, the scanner gives a one-cycle done pulse, a count of bad blocks, and a flag that rises when the count goes past the number the array tolerates (40 by default).

Top module: `nand_bbt_scan`

## Requirements
- R1: While reset is asserted and after its release, busy, done_pulse, rd_start, bad_count and too_many_bad are 0, and every map bit reads 0.
- R2: Every read request addresses row = block × 64 + page, with column 2048 and page 0 or 1. No other kind of request exists at the port.
- R3: One scan visits blocks 0, 1, … 2047 strictly in ascending order, reads page 0 of a block before its page 1, and issues no request after block 2047.
- R4: A block is recorded bad exactly when a byte read from page 0 or page 1 is not FFh. Block 0 and the last block follow the same rule.
- R5: When the page 0 byte of a block is not FFh, page 1 of that block is not read.
- R6: After a scan, bad_count equals the number of bad blocks, and map_bad shows the bit for block map_idx combinationally.
- R7: too_many_bad is 1 exactly when bad_count is greater than 40, so 40 bad blocks leave it at 0 and 41 set it.
- R8: done_pulse is high for one cycle, once per scan, and busy is 0 in the cycle after it.
- R9: A scan_go pulse that arrives while busy is 1 has no effect on the request sequence or on the results.
- R10: Accepting scan_go clears the map and the count, so no result from an earlier scan survives.
- R11: rd_start is a one-cycle strobe. The byte on rd_byte is taken in the cycle in which rd_done is high, and the next request follows only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_go | input | 1 | Start-of-scan pulse, honoured only while idle |
| busy | output | 1 | Scan in progress |
| done_pulse | output | 1 | One-cycle end-of-scan strobe |
| bad_count | output | 12 | Number of blocks found bad |
| too_many_bad | output | 1 | Bad count exceeds the tolerated limit |
| map_idx | input | 11 | Block index for the map read port |
| map_bad | output | 1 | Bad bit of block map_idx |
| rd_start | output | 1 | Read request strobe |
| rd_row | output | 17 | Row (page) address of the request |
| rd_col | output | 12 | Column address of the request |
| rd_done | input | 1 | Read completion strobe |
| rd_byte | input | 8 | Byte returned with rd_done |

## Verification
The bench aims at these corner cases:
- Markers on block 0 and on the last block. A design with an off-by-one in the walk would miss them, or would run past the end and issue one request too many.
- Markers that appear only on page 1. A design that read page 0 alone would report these blocks as good.
- Page 0 markers whose page 1 holds random bytes. A scanner that did not skip page 1 would issue extra reads, and the request-count check would catch it.
- Bad counts of exactly 40 and 41, to pin the flag threshold.
- A scan_go pulse in the middle of a scan, which would restart the block order.
- A lighter map scanned after a heavier one, which would expose stale bits that were never cleared.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } scan_state_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // A spare byte that is not in the erased state marks the block unusable.
  function automatic logic marker_says_bad(input logic [7:0] spare);
    return spare != ERASED_BYTE;
  endfunction

endpackage

// File: rtl/bbt_walker.sv
module bbt_walker
  import bbt_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARK_COL        = 2048,
  parameter int BLK_W           = 11,
  parameter int ROW_W           = 17,
  parameter int COL_W           = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_go,
  input  logic             rd_done,
  input  logic [7:0]       rd_byte,
  output logic             rd_start,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  output logic             busy,
  output logic             done_pulse,
  output logic             ev_accept,
  output logic             ev_mark,
  output logic [BLK_W-1:0] mark_blk
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  // Row of a page: block-major, page-minor.
  function automatic logic [ROW_W-1:0] row_of(input logic [BLK_W-1:0] b, input logic p);
    return ROW_W'(b) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(p);
  endfunction

  scan_state_t      state;
  logic [BLK_W-1:0] blk;
  logic             pg;

  logic sample, bad_now, block_end, at_last;

  assign sample    = (state == ST_WAIT) && rd_done;
  assign bad_now   = marker_says_bad(rd_byte);
  assign block_end = bad_now || pg;
  assign at_last   = (blk == LAST_BLK);

  assign ev_accept  = (state == ST_IDLE) && scan_go;
  assign ev_mark    = sample && bad_now;
  assign mark_blk   = blk;
  assign rd_start   = (state == ST_ISSUE);
  assign rd_row     = row_of(blk, pg);
  assign rd_col     = COL_W'(MARK_COL);
  assign busy       = (state != ST_IDLE);
  assign done_pulse = (state == ST_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      blk   <= '0;
      pg    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (scan_go) begin
            state <= ST_ISSUE;
            blk   <= '0;
            pg    <= 1'b0;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (sample) begin
            if (block_end) begin
              if (at_last) begin
                state <= ST_FINISH;
              end else begin
                blk   <= blk + 1'b1;
                pg    <= 1'b0;
                state <= ST_ISSUE;
              end
            end else begin
              pg    <= 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
  parameter int NUM_BLOCKS = 2048,
  parameter int BLK_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [NUM_BLOCKS-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else if (clear) begin
      bits <= '0;
    end else if (set_en) begin
      bits[set_idx] <= 1'b1;
    end
  end

  assign rd_bit = bits[rd_idx];

endmodule

// File: rtl/bbt_tally.sv
module bbt_tally #(
  parameter int COUNT_W   = 12,
  parameter int BAD_LIMIT = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               inc,
  output logic [COUNT_W-1:0] count,
  output logic               over
);

  function automatic logic over_limit(input logic [COUNT_W-1:0] c);
    return c > COUNT_W'(BAD_LIMIT);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  assign over = over_limit(count);

endmodule

// File: rtl/nand_bbt_scan.sv
module nand_bbt_scan #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARK_COL        = 2048,
  parameter int BAD_LIMIT       = 40,
  parameter int COL_W           = 12,
  localparam int BLK_W   = $clog2(NUM_BLOCKS),
  localparam int ROW_W   = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int COUNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_go,
  output logic               busy,
  output logic               done_pulse,
  output logic [COUNT_W-1:0] bad_count,
  output logic               too_many_bad,
  input  logic [BLK_W-1:0]   map_idx,
  output logic               map_bad,
  output logic               rd_start,
  output logic [ROW_W-1:0]   rd_row,
  output logic [COL_W-1:0]   rd_col,
  input  logic               rd_done,
  input  logic [7:0]         rd_byte
);

  logic             ev_accept;
  logic             ev_mark;
  logic [BLK_W-1:0] mark_blk;

  bbt_walker #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MARK_COL       (MARK_COL),
    .BLK_W          (BLK_W),
    .ROW_W          (ROW_W),
    .COL_W          (COL_W)
  ) i_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_go   (scan_go),
    .rd_done   (rd_done),
    .rd_byte   (rd_byte),
    .rd_start  (rd_start),
    .rd_row    (rd_row),
    .rd_col    (rd_col),
    .busy      (busy),
    .done_pulse(done_pulse),
    .ev_accept (ev_accept),
    .ev_mark   (ev_mark),
    .mark_blk  (mark_blk)
  );

  bbt_bitmap #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W)
  ) i_bitmap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ev_accept),
    .set_en (ev_mark),
    .set_idx(mark_blk),
    .rd_idx (map_idx),
    .rd_bit (map_bad)
  );

  bbt_tally #(
    .COUNT_W  (COUNT_W),
    .BAD_LIMIT(BAD_LIMIT)
  ) i_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(ev_accept),
    .inc  (ev_mark),
    .count(bad_count),
    .over (too_many_bad)
  );

endmodule

// File: rtl/nand_bbt_scan_chk.sv
module nand_bbt_scan_chk #(
  parameter int MARK_COL = 2048,
  parameter int COL_W    = 12,
  parameter int PG_W     = 6,
  parameter int COUNT_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_go,
  input logic               busy,
  input logic               done_pulse,
  input logic [COUNT_W-1:0] bad_count,
  input logic               too_many_bad,
  input logic               rd_start,
  input logic [COL_W-1:0]   rd_col,
  input logic [PG_W-1:0]    rd_page,
  input logic               ev_accept,
  input logic               ev_mark
);

  // R9
  busy_rise_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scan_go));

  // R2
  read_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> (rd_col == COL_W'(MARK_COL) && rd_page <= PG_W'(1)));

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (!busy && !done_pulse));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mark |=> (bad_count == $past(bad_count) + 1'b1));

  // R10
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (bad_count == '0));

  // R7
  flag_rise_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(too_many_bad) |-> busy);

endmodule

bind nand_bbt_scan nand_bbt_scan_chk #(
  .MARK_COL(MARK_COL),
  .COL_W   (COL_W),
  .PG_W    ($clog2(PAGES_PER_BLOCK)),
  .COUNT_W (COUNT_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_go     (scan_go),
  .busy        (busy),
  .done_pulse  (done_pulse),
  .bad_count   (bad_count),
  .too_many_bad(too_many_bad),
  .rd_start    (rd_start),
  .rd_col      (rd_col),
  .rd_page     (rd_row[$clog2(PAGES_PER_BLOCK)-1:0]),
  .ev_accept   (ev_accept),
  .ev_mark     (ev_mark)
);

// File: tb/test_nand_bbt_scan.sv
`timescale 1ns/1ps
module test_nand_bbt_scan;

  localparam int NB = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_go = 1'b0;
  logic        busy, done_pulse, too_many_bad, map_bad, rd_start;
  logic [11:0] bad_count;
  logic [10:0] map_idx = '0;
  logic [16:0] rd_row;
  logic [11:0] rd_col;
  logic        rd_done = 1'b0;
  logic [7:0]  rd_byte = 8'h00;

  always #2 clk = ~clk;

  nand_bbt_scan i_nand_bbt_scan (
    .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .busy(busy),
    .done_pulse(done_pulse), .bad_count(bad_count), .too_many_bad(too_many_bad),
    .map_idx(map_idx), .map_bad(map_bad), .rd_start(rd_start), .rd_row(rd_row),
    .rd_col(rd_col), .rd_done(rd_done), .rd_byte(rd_byte)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0]    p0 [NB];
  logic [7:0]    p1 [NB];
  logic [NB-1:0] exp_map;
  int exp_nb, exp_reads, nbad_exp;
  int exp_pg;
  int reads, dones;
  bit responder_on;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  function automatic bit is_bad(input logic [7:0] a, input logic [7:0] b);
    return (a != 8'hFF) || (b != 8'hFF);
  endfunction

  // Lower-level read port model with in-order checking (R2, R3, R11).
  initial begin
    forever begin
      @(negedge clk);
      rd_done = 1'b0;
      if (rst_n && rd_start) begin
        int blk, pg, lat;
        logic [7:0] b;
        blk = int'(rd_row) / 64;
        pg  = int'(rd_row) % 64;
        chk(rd_col == 12'd2048, "R2 column", int'(rd_col), 2048);
        chk(pg < 2, "R2 page", pg, 0);
        chk(responder_on && exp_nb < NB, "R3 request after end", exp_nb, NB - 1);
        chk(blk == exp_nb && pg == exp_pg, "R3 order", int'(rd_row), exp_nb * 64 + exp_pg);
        b = (blk < NB) ? ((pg == 0) ? p0[blk] : p1[blk]) : 8'hFF;
        if (pg > 1) b = 8'hFF;
        reads++;
        if (b != 8'hFF || exp_pg == 1) begin
          exp_nb++;
          exp_pg = 0;
        end else begin
          exp_pg = 1;
        end
        lat = 1 + int'($urandom % 3);
        repeat (lat) @(negedge clk);
        chk(!rd_start, "R11 strobe held", int'(rd_start), 0);
        rd_done = 1'b1;
        rd_byte = b;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done_pulse) dones++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  task automatic mark_block(input int i);
    logic [7:0] b;
    b = 8'($urandom % 255);
    if ($urandom % 2 == 0) begin
      p0[i] = b;
      p1[i] = 8'($urandom);
    end else begin
      p0[i] = 8'hFF;
      p1[i] = b;
    end
    exp_map[i] = 1'b1;
  endtask

  task automatic make_pattern(input int nbad, input bit pin_ends);
    int k;
    exp_map = '0;
    for (int i = 0; i < NB; i++) begin
      p0[i] = 8'hFF;
      p1[i] = 8'hFF;
    end
    k = 0;
    if (pin_ends) begin
      p0[0] = 8'h00; p1[0] = 8'h5A; exp_map[0] = 1'b1;
      p0[NB-1] = 8'hFF; p1[NB-1] = 8'hFE; exp_map[NB-1] = 1'b1;
      k = 2;
    end
    while (k < nbad) begin
      int i;
      i = int'($urandom % NB);
      if (!exp_map[i]) begin
        mark_block(i);
        k++;
      end
    end
    exp_reads = 0;
    nbad_exp  = 0;
    for (int i = 0; i < NB; i++) begin
      exp_reads += (p0[i] != 8'hFF) ? 1 : 2;
      if (is_bad(p0[i], p1[i])) nbad_exp++;
    end
  endtask

  task automatic check_map(input string req);
    int errs;
    errs = 0;
    for (int i = 0; i < NB; i++) begin
      map_idx = 11'(i);
      #1;
      if (map_bad != exp_map[i]) begin
        errs++;
        if (errs <= 4) chk(1'b0, req, int'(map_bad), int'(exp_map[i]));
      end
      @(negedge clk);
    end
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic run_scan(input bit poke_mid, input string tag);
    int d0;
    exp_nb = 0; exp_pg = 0; reads = 0; d0 = dones;
    responder_on = 1'b1;
    @(negedge clk);
    scan_go = 1'b1;
    @(negedge clk);
    scan_go = 1'b0;
    chk(busy, "R8 busy after go", int'(busy), 1);
    if (poke_mid) begin
      repeat (200) @(negedge clk);
      scan_go = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      scan_go = 1'b0;
    end
    while (dones == d0) @(negedge clk);
    chk(busy, "R8 busy during done", int'(busy), 1);
    @(negedge clk);
    chk(!busy && !done_pulse, "R8 idle after done", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(dones == d0 + 1, "R8 one done per scan", dones - d0, 1);
    chk(exp_nb == NB, "R3 all blocks walked", exp_nb, NB);
    chk(reads == exp_reads, "R5 read count", reads, exp_reads);
    chk(int'(bad_count) == nbad_exp, "R6 bad count", int'(bad_count), nbad_exp);
    chk(too_many_bad == (nbad_exp > 40), "R7 limit flag", int'(too_many_bad), int'(nbad_exp > 40));
    check_map({"R4 map ", tag});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    responder_on = 1'b0;
    reads = 0; dones = 0; exp_nb = 0; exp_pg = 0;
    exp_map = '0;
    repeat (4) @(negedge clk);
    // R1 under reset
    chk(!busy && !done_pulse && !rd_start, "R1 reset outputs", int'(busy), 0);
    chk(bad_count == 12'd0 && !too_many_bad, "R1 reset count", int'(bad_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_map("R1 reset map");

    // All blocks erased
    make_pattern(0, 1'b0);
    run_scan(1'b0, "erased");

    // Ends marked, 40 bad, mid-scan go pulse (R9)
    make_pattern(40, 1'b1);
    run_scan(1'b1, "R9 forty");

    // 41 bad: flag must rise (R7)
    make_pattern(41, 1'b0);
    run_scan(1'b0, "fortyone");

    // Lighter map after a heavy one: stale bits must be gone (R10)
    make_pattern(7, 1'b0);
    run_scan(1'b0, "R10 rescan");

    // Reset clears results (R1)
    responder_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bad_count == 12'd0 && !too_many_bad && !busy, "R1 reset after scan", int'(bad_count), 0);
    exp_map = '0;
    check_map("R1 map after reset");

    finish_up();
  end

endmodule